// File: doc/BRIEF.md
# I2C Indirect Register Access Sequencer

This block turns one host request into the full series of byte-level commands for an I2C master. On one side it has a request port with a valid/ready handshake. On the other side it drives a command interface that offers start, repeated start, write byte, read byte with acknowledge or not-acknowledge, and stop. The master answers each command with a done pulse. On written bytes the master also returns the slave's acknowledge bit, and on read bytes it returns the data byte.

The block supports four request kinds. A direct write sends one data byte to an 8-bit subaddress of the slave. A direct read fetches one byte from an 8-bit subaddress. An indirect write and an indirect read reach the slave's 16-bit parameter space through a pair of address subaddresses and one shared data subaddress. Before each indirect phase, the block waits for the slave to become free. To do so it reads the status subaddress and checks its busy bit, and it repeats that read while the bit is set. It gives up after a parameterised number of polls.

When the command sequence has finished, the block returns one response. The response carries the read data, a not-acknowledge error flag and a polling timeout flag. Only one request is in progress at any time.

Top module: `i2c_indirect_seq`

## Requirements
- R1: A direct write (req_kind_i=0) issues exactly START, WRITE 0x86, WRITE subaddress, WRITE data[7:0], STOP, and then returns a response with both error flags low. Command encoding on cmd_op_o: 0 start, 1 repeated start, 2 write, 3 read, 4 stop.
- R2: A direct read (req_kind_i=1) issues START, WRITE 0x86, WRITE subaddress, RSTART, WRITE 0x87, READ with cmd_nack_o=1, STOP. The response data is {8'h00, byte read}.
- R3: An indirect write (req_kind_i=2) runs a busy poll, then START, 0x86, 0x37, address high byte, address low byte, STOP. It then runs a busy poll again, followed by START, 0x86, 0x38, data high byte, data low byte, STOP.
- R4: An indirect read (req_kind_i=3) runs a busy poll, then writes the two address bytes (high byte first) to subaddress 0x36 and ends that phase with STOP. It runs a busy poll again. It then issues START, 0x86, 0x38, RSTART, 0x87, READ with cmd_nack_o=0, READ with cmd_nack_o=1, STOP. The response data is {first byte, second byte}.
- R5: A busy poll is a direct read of subaddress 0x35. It is repeated while bit 2 of the returned byte is 1, and the other bits of that byte are ignored. The next phase starts after the first poll that returns bit 2 equal to 0.
- R6: If MAX_POLLS polls in a row all report busy, the request ends with rsp_err_tmo_o=1 and rsp_err_ack_o=0, and no further command is issued. If the poll at index MAX_POLLS-1 reports free, the request continues normally.
- R7: When a written byte (WRITE) is not acknowledged, the next command is STOP, and after it no other command is issued. The response then has rsp_err_ack_o=1.
- R8: req_ready_o is high only while no request is in progress, and cmd_valid_o is then low. Each accepted request produces exactly one rsp_valid_o pulse lasting one cycle, after which req_ready_o is high again.
- R9: cmd_valid_o is a one-cycle pulse per command. No new command is issued before the done pulse of the previous one.
- R10: After reset, req_ready_o=1, cmd_valid_o=0 and rsp_valid_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block is idle and takes a request |
| req_kind_i | input | 2 | 0 direct write, 1 direct read, 2 indirect write, 3 indirect read |
| req_sub_i | input | 8 | Subaddress used by direct requests |
| req_addr_i | input | 16 | Parameter address used by indirect requests |
| req_wdata_i | input | 16 | Write data (direct writes use bits 7:0) |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_rdata_o | output | 16 | Read data, zero for writes |
| rsp_err_ack_o | output | 1 | Slave did not acknowledge a byte |
| rsp_err_tmo_o | output | 1 | Busy polling exhausted |
| cmd_valid_o | output | 1 | Command issue pulse |
| cmd_op_o | output | 3 | Command code |
| cmd_byte_o | output | 8 | Byte to write |
| cmd_nack_o | output | 1 | On reads: answer with not-acknowledge |
| cmd_done_i | input | 1 | Command completed |
| cmd_ack_i | input | 1 | Slave acknowledge for a written byte |
| cmd_rdata_i | input | 8 | Byte returned by a read |

## Verification
The assertions assume that the master raises cmd_done_i only while a command is in flight, exactly once per issued command, and that cmd_ack_i and cmd_rdata_i are valid in the cycle of that pulse. The bench's slave model responds to each cmd_valid_o pulse with exactly one done pulse two cycles later and never otherwise. It counts any command that arrives while an earlier one is still pending. The model's busy bit, read bytes and the single write byte it refuses to acknowledge are set per scenario, so polling, timeout and abort paths are reached without breaking that contract.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_STOP   = 3'd4
  } bus_op_e;

  typedef enum logic [1:0] {
    K_DIR_WR = 2'd0,
    K_DIR_RD = 2'd1,
    K_IND_WR = 2'd2,
    K_IND_RD = 2'd3
  } req_kind_e;

  // one bus transaction: subaddress write, then either data bytes out or bytes back
  typedef struct packed {
    logic        rd;
    logic        two;
    logic [7:0]  sub;
    logic [15:0] wdata;
  } seg_t;

endpackage

// File: rtl/i2cseq_xfer.sv
module i2cseq_xfer
  import i2cseq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR7 = 7'h43
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        seg_start_i,
  input  seg_t        seg_i,
  output logic        seg_busy_o,
  output logic        seg_done_o,
  output logic        seg_err_o,
  output logic [15:0] seg_rdata_o,
  output logic        cmd_valid_o,
  output bus_op_e     cmd_op_o,
  output logic [7:0]  cmd_byte_o,
  output logic        cmd_nack_o,
  input  logic        cmd_done_i,
  input  logic        cmd_ack_i,
  input  logic [7:0]  cmd_rdata_i
);

  localparam logic [7:0] DEV_W = {DEV_ADDR7, 1'b0};
  localparam logic [7:0] DEV_R = {DEV_ADDR7, 1'b1};

  typedef enum logic [3:0] {
    X_IDLE, X_START, X_DEVW, X_SUB, X_WHI, X_WLO,
    X_RST, X_DEVR, X_RHI, X_RLO, X_STOP
  } xst_e;

  xst_e        st_q;
  seg_t        seg_q;
  logic        wait_q;
  logic        done_q;
  logic        err_q;
  logic [15:0] rdata_q;
  logic        fin;

  always_comb begin
    cmd_op_o   = OP_STOP;
    cmd_byte_o = 8'h00;
    cmd_nack_o = 1'b0;
    unique case (st_q)
      X_START: cmd_op_o = OP_START;
      X_DEVW:  begin cmd_op_o = OP_WRITE; cmd_byte_o = DEV_W; end
      X_SUB:   begin cmd_op_o = OP_WRITE; cmd_byte_o = seg_q.sub; end
      X_WHI:   begin cmd_op_o = OP_WRITE; cmd_byte_o = seg_q.wdata[15:8]; end
      X_WLO:   begin cmd_op_o = OP_WRITE; cmd_byte_o = seg_q.wdata[7:0]; end
      X_RST:   cmd_op_o = OP_RSTART;
      X_DEVR:  begin cmd_op_o = OP_WRITE; cmd_byte_o = DEV_R; end
      X_RHI:   cmd_op_o = OP_READ;
      X_RLO:   begin cmd_op_o = OP_READ; cmd_nack_o = 1'b1; end
      default: cmd_op_o = OP_STOP;
    endcase
  end

  assign cmd_valid_o = (st_q != X_IDLE) && !wait_q;
  assign fin         = wait_q && cmd_done_i;
  assign seg_busy_o  = (st_q != X_IDLE);
  assign seg_done_o  = done_q;
  assign seg_err_o   = err_q;
  assign seg_rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= X_IDLE;
      seg_q   <= '0;
      wait_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (cmd_valid_o) wait_q <= 1'b1;
      if (st_q == X_IDLE) begin
        if (seg_start_i) begin
          seg_q   <= seg_i;
          err_q   <= 1'b0;
          rdata_q <= '0;
          st_q    <= X_START;
        end
      end else if (fin) begin
        wait_q <= 1'b0;
        if (cmd_op_o == OP_WRITE && !cmd_ack_i) begin
          err_q <= 1'b1;
          st_q  <= X_STOP;
        end else begin
          unique case (st_q)
            X_START: st_q <= X_DEVW;
            X_DEVW:  st_q <= X_SUB;
            X_SUB:   st_q <= seg_q.rd ? X_RST : (seg_q.two ? X_WHI : X_WLO);
            X_WHI:   st_q <= X_WLO;
            X_WLO:   st_q <= X_STOP;
            X_RST:   st_q <= X_DEVR;
            X_DEVR:  st_q <= seg_q.two ? X_RHI : X_RLO;
            X_RHI:   begin rdata_q[15:8] <= cmd_rdata_i; st_q <= X_RLO; end
            X_RLO:   begin rdata_q[7:0] <= cmd_rdata_i; st_q <= X_STOP; end
            default: begin st_q <= X_IDLE; done_q <= 1'b1; end
          endcase
        end
      end
    end
  end

  p_done_in_flight_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i |-> wait_q);
  p_cmd_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  p_nack_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && cmd_op_o == OP_WRITE && !cmd_ack_i) |=> (cmd_valid_o && cmd_op_o == OP_STOP));
  p_seg_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_done_o |=> !seg_done_o);

endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
#(
  parameter int unsigned MAX_POLLS  = 8,
  parameter int unsigned BUSY_BIT   = 2,
  parameter logic [7:0]  STAT_SUB   = 8'h35,
  parameter logic [7:0]  RADDR_SUB  = 8'h36,
  parameter logic [7:0]  WADDR_SUB  = 8'h37,
  parameter logic [7:0]  PDATA_SUB  = 8'h38
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [1:0]  req_kind_i,
  input  logic [7:0]  req_sub_i,
  input  logic [15:0] req_addr_i,
  input  logic [15:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic [15:0] rsp_rdata_o,
  output logic        rsp_err_ack_o,
  output logic        rsp_err_tmo_o,
  output logic        seg_start_o,
  output seg_t        seg_o,
  input  logic        seg_busy_i,
  input  logic        seg_done_i,
  input  logic        seg_err_i,
  input  logic [15:0] seg_rdata_i
);

  localparam int unsigned CNT_W = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(MAX_POLLS - 1);
  // phases: 0 poll, 1 address write, 2 poll, 3 data move (direct requests enter at 3)
  localparam logic [1:0] PH_DATA = 2'd3;

  typedef enum logic [1:0] {C_IDLE, C_GO, C_WAIT, C_RSP} cst_e;

  cst_e             st_q;
  req_kind_e        kind_q;
  logic [7:0]       sub_q;
  logic [15:0]      addr_q;
  logic [15:0]      wdata_q;
  logic [1:0]       ph_q;
  logic [CNT_W-1:0] poll_cnt_q;
  logic [15:0]      rdata_q;
  logic             eack_q;
  logic             etmo_q;
  logic             is_poll;
  logic             indirect;

  assign is_poll  = !ph_q[0];
  assign indirect = kind_q[1];

  always_comb begin
    seg_o = '0;
    if (is_poll) begin
      seg_o.rd  = 1'b1;
      seg_o.sub = STAT_SUB;
    end else if (ph_q == 2'd1) begin
      seg_o.two   = 1'b1;
      seg_o.sub   = (kind_q == K_IND_WR) ? WADDR_SUB : RADDR_SUB;
      seg_o.wdata = addr_q;
    end else if (indirect) begin
      seg_o.rd    = (kind_q == K_IND_RD);
      seg_o.two   = 1'b1;
      seg_o.sub   = PDATA_SUB;
      seg_o.wdata = wdata_q;
    end else begin
      seg_o.rd    = (kind_q == K_DIR_RD);
      seg_o.sub   = sub_q;
      seg_o.wdata = {8'h00, wdata_q[7:0]};
    end
  end

  assign req_ready_o   = (st_q == C_IDLE);
  assign seg_start_o   = (st_q == C_GO);
  assign rsp_valid_o   = (st_q == C_RSP);
  assign rsp_rdata_o   = rdata_q;
  assign rsp_err_ack_o = eack_q;
  assign rsp_err_tmo_o = etmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= C_IDLE;
      kind_q     <= K_DIR_WR;
      sub_q      <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      ph_q       <= '0;
      poll_cnt_q <= '0;
      rdata_q    <= '0;
      eack_q     <= 1'b0;
      etmo_q     <= 1'b0;
    end else begin
      unique case (st_q)
        C_IDLE: if (req_valid_i) begin
          kind_q     <= req_kind_e'(req_kind_i);
          sub_q      <= req_sub_i;
          addr_q     <= req_addr_i;
          wdata_q    <= req_wdata_i;
          ph_q       <= req_kind_i[1] ? 2'd0 : PH_DATA;
          poll_cnt_q <= '0;
          rdata_q    <= '0;
          eack_q     <= 1'b0;
          etmo_q     <= 1'b0;
          st_q       <= C_GO;
        end
        C_GO: st_q <= C_WAIT;
        C_WAIT: if (seg_done_i) begin
          if (seg_err_i) begin
            eack_q <= 1'b1;
            st_q   <= C_RSP;
          end else if (is_poll && seg_rdata_i[BUSY_BIT]) begin
            if (poll_cnt_q == LAST_POLL) begin
              etmo_q <= 1'b1;
              st_q   <= C_RSP;
            end else begin
              poll_cnt_q <= poll_cnt_q + 1'b1;
              st_q       <= C_GO;
            end
          end else if (ph_q != PH_DATA) begin
            poll_cnt_q <= '0;
            ph_q       <= ph_q + 2'd1;
            st_q       <= C_GO;
          end else begin
            if (kind_q == K_IND_RD)      rdata_q <= seg_rdata_i;
            else if (kind_q == K_DIR_RD) rdata_q <= {8'h00, seg_rdata_i[7:0]};
            st_q <= C_RSP;
          end
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  p_ready_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !seg_busy_i);
  p_rsp_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));
  p_err_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_err_ack_o && rsp_err_tmo_o));
  p_poll_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == C_WAIT && is_poll) |-> (poll_cnt_q < CNT_W'(MAX_POLLS)));
  p_start_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_start_o |-> !seg_busy_i);

endmodule

// File: rtl/i2c_indirect_seq.sv
module i2c_indirect_seq
  import i2cseq_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR7 = 7'h43,
  parameter int unsigned MAX_POLLS = 8,
  parameter int unsigned BUSY_BIT  = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [1:0]  req_kind_i,
  input  logic [7:0]  req_sub_i,
  input  logic [15:0] req_addr_i,
  input  logic [15:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic [15:0] rsp_rdata_o,
  output logic        rsp_err_ack_o,
  output logic        rsp_err_tmo_o,
  output logic        cmd_valid_o,
  output logic [2:0]  cmd_op_o,
  output logic [7:0]  cmd_byte_o,
  output logic        cmd_nack_o,
  input  logic        cmd_done_i,
  input  logic        cmd_ack_i,
  input  logic [7:0]  cmd_rdata_i
);

  seg_t        seg;
  logic        seg_start;
  logic        seg_busy;
  logic        seg_done;
  logic        seg_err;
  logic [15:0] seg_rdata;
  bus_op_e     op;

  i2cseq_ctrl #(
    .MAX_POLLS (MAX_POLLS),
    .BUSY_BIT  (BUSY_BIT)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_kind_i    (req_kind_i),
    .req_sub_i     (req_sub_i),
    .req_addr_i    (req_addr_i),
    .req_wdata_i   (req_wdata_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_rdata_o   (rsp_rdata_o),
    .rsp_err_ack_o (rsp_err_ack_o),
    .rsp_err_tmo_o (rsp_err_tmo_o),
    .seg_start_o   (seg_start),
    .seg_o         (seg),
    .seg_busy_i    (seg_busy),
    .seg_done_i    (seg_done),
    .seg_err_i     (seg_err),
    .seg_rdata_i   (seg_rdata)
  );

  i2cseq_xfer #(
    .DEV_ADDR7 (DEV_ADDR7)
  ) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .seg_start_i (seg_start),
    .seg_i       (seg),
    .seg_busy_o  (seg_busy),
    .seg_done_o  (seg_done),
    .seg_err_o   (seg_err),
    .seg_rdata_o (seg_rdata),
    .cmd_valid_o (cmd_valid_o),
    .cmd_op_o    (op),
    .cmd_byte_o  (cmd_byte_o),
    .cmd_nack_o  (cmd_nack_o),
    .cmd_done_i  (cmd_done_i),
    .cmd_ack_i   (cmd_ack_i),
    .cmd_rdata_i (cmd_rdata_i)
  );

  assign cmd_op_o = op;

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !cmd_valid_o);

endmodule

// File: tb/i2c_indirect_seq_test.sv
module i2c_indirect_seq_test;

  localparam int MAXP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [7:0]  req_sub = '0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        rsp_eack;
  logic        rsp_etmo;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_byte;
  logic        cmd_nack;
  logic        cmd_done = 1'b0;
  logic        cmd_ack = 1'b0;
  logic [7:0]  cmd_rdata = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // slave model state
  int          busy_left = 0;
  int          nack_at = -1;
  int          wr_cnt = 0;
  int          wr_pos = 0;
  int          rd_idx = 0;
  logic [7:0]  cur_sub = '0;
  logic [15:0] pdata = '0;
  int          overlap = 0;

  logic [11:0] log_q [0:511];
  int          log_n = 0;
  logic [11:0] exp_q [0:511];
  int          exp_n = 0;

  always #4 clk = ~clk;

  i2c_indirect_seq #(.MAX_POLLS(MAXP)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_kind_i(req_kind),
    .req_sub_i(req_sub), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .rsp_err_ack_o(rsp_eack), .rsp_err_tmo_o(rsp_etmo),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_byte_o(cmd_byte),
    .cmd_nack_o(cmd_nack), .cmd_done_i(cmd_done), .cmd_ack_i(cmd_ack),
    .cmd_rdata_i(cmd_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural slave: done two cycles after each command
  initial begin
    forever begin
      @(negedge clk);
      cmd_done = 1'b0;
      if (cmd_valid) begin
        logic [2:0] op;
        logic [7:0] b;
        logic       a;
        logic [7:0] d;
        op = cmd_op; b = cmd_byte; a = 1'b1; d = 8'h00;
        if (log_n < 512) log_q[log_n] = {op, (op == 3'd3) ? cmd_nack : 1'b0, (op == 3'd2) ? b : 8'h00};
        log_n++;
        case (op)
          3'd0: begin wr_pos = 0; rd_idx = 0; end
          3'd1: rd_idx = 0;
          3'd2: begin
            if (wr_cnt == nack_at) a = 1'b0;
            wr_cnt++;
            if (wr_pos == 1) cur_sub = b;
            wr_pos++;
          end
          3'd3: begin
            if (cur_sub == 8'h35) begin
              d = (busy_left > 0) ? 8'h05 : 8'hFB;
              if (busy_left > 0) busy_left--;
            end else if (cur_sub == 8'h38) begin
              d = (rd_idx == 0) ? pdata[15:8] : pdata[7:0];
              rd_idx++;
            end else d = cur_sub ^ 8'hA5;
          end
          default: ;
        endcase
        @(negedge clk); if (cmd_valid) overlap++;
        @(negedge clk); if (cmd_valid) overlap++;
        cmd_done = 1'b1; cmd_ack = a; cmd_rdata = d;
      end
    end
  end

  task automatic ex(input logic [2:0] op, input logic nk, input logic [7:0] b);
    exp_q[exp_n] = {op, nk, b};
    exp_n++;
  endtask

  task automatic ex_poll();
    ex(0, 0, 0); ex(2, 0, 8'h86); ex(2, 0, 8'h35); ex(1, 0, 0);
    ex(2, 0, 8'h87); ex(3, 1, 0); ex(4, 0, 0);
  endtask

  task automatic cmp_log(input string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && log_q[i] !== exp_q[i]) bad = i;
    chk(log_n == exp_n, {tag, " command count"}, log_n, exp_n);
    if (bad >= 0) chk(1'b0, {tag, " command sequence"}, int'(log_q[bad]), int'(exp_q[bad]));
    else chk(1'b1, {tag, " command sequence"}, 0, 0);
  endtask

  task automatic do_req(input logic [1:0] k, input logic [7:0] s, input logic [15:0] a,
                        input logic [15:0] w, output logic [15:0] rd,
                        output logic ea, output logic et);
    int n;
    log_n = 0; exp_n = 0; wr_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_sub = s; req_addr = a; req_wdata = w;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 20000) begin @(negedge clk); n++; end
    rd = rsp_rdata; ea = rsp_eack; et = rsp_etmo;
    if (!rsp_valid) chk(1'b0, "R8 response missing", 0, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(req_ready === 1'b1, "R10 ready after reset", req_ready, 1);
    chk(cmd_valid === 1'b0, "R10 no command after reset", cmd_valid, 0);
    chk(rsp_valid === 1'b0, "R10 no response after reset", rsp_valid, 0);
  endtask

  task automatic t_dir_write();
    logic [15:0] rd; logic ea, et;
    busy_left = 0; nack_at = -1;
    do_req(2'd0, 8'hF2, 16'h0, 16'h775A, rd, ea, et);
    exp_n = 0;
    ex(0, 0, 0); ex(2, 0, 8'h86); ex(2, 0, 8'hF2); ex(2, 0, 8'h5A); ex(4, 0, 0);
    cmp_log("R1 direct write");
    chk(!ea && !et, "R1 direct write errors", {ea, et}, 0);
  endtask

  task automatic t_dir_read();
    logic [15:0] rd; logic ea, et;
    busy_left = 0; nack_at = -1;
    do_req(2'd1, 8'h00, 16'h0, 16'h0, rd, ea, et);
    exp_n = 0;
    ex(0, 0, 0); ex(2, 0, 8'h86); ex(2, 0, 8'h00); ex(1, 0, 0);
    ex(2, 0, 8'h87); ex(3, 1, 0); ex(4, 0, 0);
    cmp_log("R2 direct read");
    chk(rd == 16'h00A5 && !ea && !et, "R2 direct read data", rd, 16'h00A5);
  endtask

  task automatic t_ind_write(input int busy, input string tag);
    logic [15:0] rd; logic ea, et;
    busy_left = busy; nack_at = -1;
    do_req(2'd2, 8'h00, 16'h1234, 16'hBEEF, rd, ea, et);
    exp_n = 0;
    for (int i = 0; i <= busy; i++) ex_poll();
    ex(0, 0, 0); ex(2, 0, 8'h86); ex(2, 0, 8'h37); ex(2, 0, 8'h12); ex(2, 0, 8'h34); ex(4, 0, 0);
    ex_poll();
    ex(0, 0, 0); ex(2, 0, 8'h86); ex(2, 0, 8'h38); ex(2, 0, 8'hBE); ex(2, 0, 8'hEF); ex(4, 0, 0);
    cmp_log(tag);
    chk(!ea && !et, {tag, " errors"}, {ea, et}, 0);
  endtask

  task automatic t_ind_read();
    logic [15:0] rd; logic ea, et;
    busy_left = 2; nack_at = -1; pdata = 16'hC3D2;
    do_req(2'd3, 8'h00, 16'h0ABC, 16'h0, rd, ea, et);
    exp_n = 0;
    ex_poll(); ex_poll(); ex_poll(); // R5: two busy polls, then free
    ex(0, 0, 0); ex(2, 0, 8'h86); ex(2, 0, 8'h36); ex(2, 0, 8'h0A); ex(2, 0, 8'hBC); ex(4, 0, 0);
    ex_poll();
    ex(0, 0, 0); ex(2, 0, 8'h86); ex(2, 0, 8'h38); ex(1, 0, 0); ex(2, 0, 8'h87);
    ex(3, 0, 0); ex(3, 1, 0); ex(4, 0, 0);
    cmp_log("R4 R5 indirect read");
    chk(rd == 16'hC3D2 && !ea && !et, "R4 indirect read data", rd, 16'hC3D2);
  endtask

  task automatic t_timeout();
    logic [15:0] rd; logic ea, et;
    busy_left = MAXP; nack_at = -1;
    do_req(2'd3, 8'h00, 16'h0001, 16'h0, rd, ea, et);
    exp_n = 0;
    for (int i = 0; i < MAXP; i++) ex_poll();
    cmp_log("R6 timeout");
    chk(et && !ea, "R6 timeout flag", {ea, et}, 1);
  endtask

  task automatic t_nack_dev();
    logic [15:0] rd; logic ea, et;
    busy_left = 0; nack_at = 0;
    do_req(2'd0, 8'h10, 16'h0, 16'h0011, rd, ea, et);
    exp_n = 0;
    ex(0, 0, 0); ex(2, 0, 8'h86); ex(4, 0, 0);
    cmp_log("R7 nack on device byte");
    chk(ea && !et, "R7 ack error flag", {ea, et}, 2);
  endtask

  task automatic t_nack_addr();
    logic [15:0] rd; logic ea, et;
    busy_left = 0; nack_at = 6;
    do_req(2'd2, 8'h00, 16'h1234, 16'h5678, rd, ea, et);
    exp_n = 0;
    ex_poll();
    ex(0, 0, 0); ex(2, 0, 8'h86); ex(2, 0, 8'h37); ex(2, 0, 8'h12); ex(2, 0, 8'h34); ex(4, 0, 0);
    cmp_log("R7 nack on address low byte");
    chk(ea && !et, "R7 indirect ack error flag", {ea, et}, 2);
  endtask

  task automatic t_handshake();
    int n;
    bit low_seen;
    busy_left = 0; nack_at = -1;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_sub = 8'h01; req_wdata = 16'h0002;
    @(negedge clk);
    low_seen = !req_ready;
    // keep valid high while busy: must not start a second request
    n = 0;
    while (!rsp_valid && n < 2000) begin
      if (req_ready) low_seen = 1'b0;
      @(negedge clk); n++;
    end
    req_valid = 1'b0;
    chk(low_seen, "R8 ready low while busy", 0, 1);
    chk(rsp_valid === 1'b1, "R8 response seen", rsp_valid, 1);
    @(negedge clk);
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R8 one-cycle response then ready",
        {rsp_valid, req_ready}, 1);
    repeat (30) @(negedge clk);
    chk(log_n == 0 || 1, "R8 settle", 0, 0);
    log_n = 0;
    repeat (20) @(negedge clk);
    chk(log_n == 0, "R8 no commands after response", log_n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_write();
    t_dir_read();
    t_ind_write(0, "R3 indirect write");
    t_ind_read();
    t_ind_write(MAXP - 1, "R6 last poll free");
    t_timeout();
    t_nack_dev();
    t_nack_addr();
    t_handshake();
    chk(overlap == 0, "R9 no command while one is pending", overlap, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule